// File: doc/BRIEF.md
# DMA Address and Transfer-Count Register Pair

This block keeps the programmable state of a DMA engine as the CPU sees it: a 22-bit, always-even transfer address and a 14-bit transfer count, together with a direction flag and an enable flag. The transfer engine that moves the data is a separate block. It reads the address, count and flags from this block's outputs. It sends back one step pulse for each transfer it completes.

The address is not loaded from the data bus. The CPU writes it through the address lines of a store into the address window. One address line chooses which half is replaced: the upper thirteen bits or the lower eight word bits. The bits of the other half are kept. A store to the count window takes the count and both control flags from the data bus. The count is then bumped by one as part of that same store. Reading the count window returns the count with its two top bits forced high.

Top module: `dmar_top`

## Requirements
- R1: A count-window write (`cnt_wr`=1) stores `wdata[13:0]` plus one as the count, wrapping within 14 bits (writing 0x3FFF leaves 0); the new count is visible at the next clock edge.
- R2: The same count-window write sets the direction flag from `wdata[14]` and the enable flag from `wdata[15]`.
- R3: `cnt_rdata` always equals the stored count in bits [13:0], with bits 15 and 14 reading as 1.
- R4: An address-window write with `reg_addr[14]`=1 loads DMA address bits [21:9] from `reg_addr[13:1]` and keeps bits [8:1].
- R5: An address-window write with `reg_addr[14]`=0 loads DMA address bits [8:1] from `reg_addr[8:1]` and keeps bits [21:9].
- R6: DMA address bit 0 always reads 0.
- R7: A `step` pulse adds one to the count (wrapping 0x3FFF to 0) and two to the address (wrapping 0x3FFFFE to 0). It leaves the direction and enable flags unchanged.
- R8: When a register write and a `step` land in the same cycle, the written register takes the written value and ignores the step; the other register still advances.
- R9: Reset clears the address, the count, the direction flag and the enable flag.
- R10: With no strobe and no `step`, every output holds its value whatever `wdata` and `reg_addr` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_wr | input | 1 | Store into the address window this cycle |
| cnt_wr | input | 1 | Store into the count window this cycle |
| reg_addr | input | 14 | CPU address lines [14:1]; bit 14 selects the half |
| wdata | input | 16 | CPU write data for the count window |
| step | input | 1 | One transfer done by the engine |
| dma_addr | output | 22 | Current DMA byte address, even |
| dma_count | output | 14 | Current transfer count |
| dma_dir | output | 1 | Direction flag |
| dma_en | output | 1 | Enable flag |
| cnt_rdata | output | 16 | Count-window read-back value |

## Verification
Every register result is due one clock edge after its strobe or step. This applies to the address halves, the count, both flags and the combined write-plus-step cases. The bench drives inputs on the falling edge. It samples the outputs on the next falling edge, which is half a period after the rising edge that takes them. The read-back word has no register of its own, so it is checked on that same falling edge against the count then held. A behavioural model advances on each rising edge and is compared on every falling edge. Directed checks at the wrap points, the half-select boundaries and the collision cycles sit on top of that comparison.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    localparam int DEF_LOW_W  = 8;
    localparam int DEF_HIGH_W = 13;
    localparam int DEF_CNT_W  = 14;

    typedef enum logic [1:0] {
        ADDR_HOLD    = 2'd0,
        ADDR_LOAD_LO = 2'd1,
        ADDR_LOAD_HI = 2'd2,
        ADDR_STEP    = 2'd3
    } addr_op_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
(
    input  logic     addr_wr,
    input  logic     cnt_wr,
    input  logic     half_sel,
    input  logic     step,
    output addr_op_e addr_op,
    output cnt_op_e  cnt_op
);

    // A CPU store outranks the engine step for the register it targets (R8).
    always_comb begin
        if (addr_wr) begin
            addr_op = half_sel ? ADDR_LOAD_HI : ADDR_LOAD_LO;
        end else if (step) begin
            addr_op = ADDR_STEP;
        end else begin
            addr_op = ADDR_HOLD;
        end
    end

    always_comb begin
        if (cnt_wr) begin
            cnt_op = CNT_LOAD;
        end else if (step) begin
            cnt_op = CNT_STEP;
        end else begin
            cnt_op = CNT_HOLD;
        end
    end

endmodule

// File: rtl/dmar_addr_reg.sv
module dmar_addr_reg
    import dmar_pkg::*;
#(
    parameter int LOW_W  = DEF_LOW_W,
    parameter int HIGH_W = DEF_HIGH_W,
    localparam int WORD_W = LOW_W + HIGH_W,
    localparam int AW     = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_op_e          op,
    input  logic [HIGH_W:1]   src,
    output logic [AW-1:0]     addr_o
);

    typedef struct packed {
        logic [HIGH_W-1:0] hi;
        logic [LOW_W-1:0]  lo;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            ADDR_LOAD_HI: st_d.hi = src[HIGH_W:1];
            ADDR_LOAD_LO: st_d.lo = src[LOW_W:1];
            ADDR_STEP:    st_d    = addr_st_t'(st_q + 1'b1);
            default:      st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Word storage only; the byte bit is tied low (R6).
    assign addr_o = {st_q, 1'b0};

    assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADDR_LOAD_HI) |=> (addr_o[LOW_W:1] == $past(addr_o[LOW_W:1])));

    assert_lo_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADDR_LOAD_LO) |=> (addr_o[AW-1:LOW_W+1] == $past(addr_o[AW-1:LOW_W+1])));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADDR_STEP) |=> (addr_o == AW'($past(addr_o) + AW'(2))));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADDR_HOLD) |=> $stable(addr_o));

endmodule

// File: rtl/dmar_cnt_reg.sv
module dmar_cnt_reg
    import dmar_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    localparam int DW   = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             en_o,
    output logic [DW-1:0]    rdata_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             en;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            CNT_LOAD: begin
                st_d.cnt = wdata[CNT_W-1:0] + 1'b1;
                st_d.dir = wdata[CNT_W];
                st_d.en  = wdata[CNT_W+1];
            end
            CNT_STEP: st_d.cnt = st_q.cnt + 1'b1;
            default:  st_d     = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign dir_o   = st_q.dir;
    assign en_o    = st_q.en;
    assign rdata_o = {2'b11, st_q.cnt};

    assert_cnt_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_LOAD) |=> (cnt_o == CNT_W'($past(wdata[CNT_W-1:0]) + 1'b1)));

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_LOAD) |=> ({en_o, dir_o} == $past(wdata[CNT_W+1:CNT_W])));

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_STEP) |=> ((cnt_o == CNT_W'($past(cnt_o) + 1'b1)) && $stable(dir_o) && $stable(en_o)));

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_HOLD) |=> ($stable(cnt_o) && $stable(dir_o) && $stable(en_o)));

endmodule

// File: rtl/dmar_top.sv
module dmar_top
    import dmar_pkg::*;
#(
    parameter int LOW_W  = DEF_LOW_W,
    parameter int HIGH_W = DEF_HIGH_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int AW    = LOW_W + HIGH_W + 1,
    localparam int SEL_B = HIGH_W + 1,
    localparam int DW    = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_wr,
    input  logic             cnt_wr,
    input  logic [SEL_B:1]   reg_addr,
    input  logic [DW-1:0]    wdata,
    input  logic             step,
    output logic [AW-1:0]    dma_addr,
    output logic [CNT_W-1:0] dma_count,
    output logic             dma_dir,
    output logic             dma_en,
    output logic [DW-1:0]    cnt_rdata
);

    addr_op_e addr_op;
    cnt_op_e  cnt_op;

    dmar_decode u_decode (
        .addr_wr (addr_wr),
        .cnt_wr  (cnt_wr),
        .half_sel(reg_addr[SEL_B]),
        .step    (step),
        .addr_op (addr_op),
        .cnt_op  (cnt_op)
    );

    dmar_addr_reg #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (addr_op),
        .src   (reg_addr[HIGH_W:1]),
        .addr_o(dma_addr)
    );

    dmar_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (cnt_op),
        .wdata  (wdata),
        .cnt_o  (dma_count),
        .dir_o  (dma_dir),
        .en_o   (dma_en),
        .rdata_o(cnt_rdata)
    );

    assert_wr_beats_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && step) |=> (dma_count == CNT_W'($past(wdata[CNT_W-1:0]) + 1'b1)));

endmodule

// File: tb/dmar_top_tb.sv
module dmar_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_wr = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [14:1] reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        step = 1'b0;
    logic [21:0] dma_addr;
    logic [13:0] dma_count;
    logic        dma_dir;
    logic        dma_en;
    logic [15:0] cnt_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model state
    int unsigned m_addr = 0;
    int unsigned m_cnt  = 0;
    int unsigned m_dir  = 0;
    int unsigned m_en   = 0;

    always #10 clk = ~clk;

    dmar_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .cnt_wr(cnt_wr),
        .reg_addr(reg_addr), .wdata(wdata), .step(step),
        .dma_addr(dma_addr), .dma_count(dma_count), .dma_dir(dma_dir),
        .dma_en(dma_en), .cnt_rdata(cnt_rdata)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural model, byte-address arithmetic on full integers.
    always @(posedge clk) begin
        int unsigned a;
        a = {17'd0, reg_addr, 1'b0};
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_dir = 0; m_en = 0;
        end else begin
            if (cnt_wr) begin
                m_cnt = ((wdata & 32'h3FFF) + 1) & 32'h3FFF;
                m_dir = (wdata >> 14) & 1;
                m_en  = (wdata >> 15) & 1;
            end else if (step) begin
                m_cnt = (m_cnt + 1) & 32'h3FFF;
            end
            if (addr_wr) begin
                if (a & 32'h4000) m_addr = (m_addr & 32'h1FE) | ((a & 32'h3FFE) << 8);
                else              m_addr = (m_addr & 32'h3FFE00) | (a & 32'h1FE);
            end else if (step) begin
                m_addr = (m_addr + 2) & 32'h3FFFFF;
            end
        end
    end

    // Per-cycle comparison half a period after each rising edge.
    always @(negedge clk) begin
        cyc++;
        chk("R4 R5 R7 R9 model dma_addr", dma_addr, m_addr);
        chk("R1 R7 R9 model dma_count", dma_count, m_cnt);
        chk("R2 R9 model dma_dir", dma_dir, m_dir);
        chk("R2 R9 model dma_en", dma_en, m_en);
        chk("R3 model cnt_rdata", cnt_rdata, 32'hC000 | m_cnt);
        chk("R6 addr bit0", dma_addr[0], 0);
        if (cyc > 5000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Called at a falling edge; applies one cycle of stimulus and returns at the next falling edge.
    task automatic apply(input logic aw, input logic cw, input logic st,
                         input logic [15:0] a, input logic [15:0] d);
        addr_wr  = aw;
        cnt_wr   = cw;
        step     = st;
        reg_addr = a[14:1];
        wdata    = d;
        @(negedge clk);
        addr_wr = 1'b0;
        cnt_wr  = 1'b0;
        step    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset addr", dma_addr, 0);
        chk("R9 reset count", dma_count, 0);
        chk("R9 reset en", dma_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        apply(0, 1, 0, 16'h0000, 16'h8005);
        chk("R1 count load+1", dma_count, 14'h0006);
        chk("R2 enable set", dma_en, 1);
        chk("R2 dir clear", dma_dir, 0);
        chk("R3 readback", cnt_rdata, 16'hC006);

        apply(0, 1, 0, 16'h0000, 16'h7FFF);
        chk("R1 count wrap on load", dma_count, 0);
        chk("R2 dir set en clear", {dma_en, dma_dir}, 2'b01);
        chk("R3 readback zero", cnt_rdata, 16'hC000);

        apply(1, 0, 0, 16'h6AAA, 16'hFFFF);
        chk("R4 high half", dma_addr, 22'h2AAA00);
        apply(1, 0, 0, 16'h0155, 16'h0000);
        chk("R5 low half", dma_addr, 22'h2AAB54);
        apply(1, 0, 0, 16'h4002, 16'h0000);
        chk("R4 high keeps low", dma_addr, 22'h000354);

        apply(0, 0, 1, 16'h0000, 16'h0000);
        chk("R7 step addr", dma_addr, 22'h000356);
        chk("R7 step count", dma_count, 1);
        chk("R7 flags kept", {dma_en, dma_dir}, 2'b01);

        apply(1, 0, 0, 16'h7FFE, 16'h0000);
        apply(1, 0, 0, 16'h01FE, 16'h0000);
        chk("R4 R5 top address", dma_addr, 22'h3FFFFE);
        apply(0, 1, 0, 16'h0000, 16'hC000 | 16'h3FFE);
        chk("R1 count at max", dma_count, 14'h3FFF);
        apply(0, 0, 1, 16'h0000, 16'h0000);
        chk("R7 addr wrap", dma_addr, 0);
        chk("R7 count wrap", dma_count, 0);

        apply(0, 1, 1, 16'h0000, 16'h0010);
        chk("R8 count write wins", dma_count, 14'h0011);
        chk("R8 addr still steps", dma_addr, 22'h000002);
        apply(1, 0, 1, 16'h0020, 16'h0000);
        chk("R8 addr write wins", dma_addr, 22'h000020);
        chk("R8 count still steps", dma_count, 14'h0012);

        for (int i = 0; i < 4; i++) begin
            apply(0, 0, 0, 16'h7FFF ^ 16'(i * 16'h1357), 16'hFFFF ^ 16'(i * 16'h2468));
            chk("R10 addr held", dma_addr, 22'h000020);
            chk("R10 count held", dma_count, 14'h0012);
        end

        for (int i = 0; i < 40; i++) begin
            apply(1'((i * 7) % 3 == 0), 1'((i * 5) % 4 == 1), 1'(i % 2),
                  16'(i * 16'h0B3D), 16'(i * 16'h4F1B));
        end

        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears addr", dma_addr, 0);
        chk("R9 reset clears flags", {dma_en, dma_dir}, 0);
        finish_run();
    end

endmodule